// File: doc/BRIEF.md
# SPI Transmit Frame Buffer with Status Flags

This block sits between a register-write port and an SPI shift register. Software queues outgoing frames by writing a push register. The buffer hands its oldest frame to the shift register in any cycle where the shifter reports that it is ready and at least one frame is queued. Software can empty the buffer at once with a flush strobe.

The block keeps an occupancy counter and three status flags. The fill-request flag says there is room for another frame. Its output goes to either a DMA request line or an interrupt line, chosen by a route select input. The done flag records that a frame has finished shifting. The underflow flag records that, in slave mode, an external master began a transfer while nothing was queued. All three flags are cleared by write-one-to-clear strobes. A push into a full buffer is dropped without any error indication.

Top module: `spi_tx_fifo`

## Requirements
- R1: While reset is held and directly after it is released, the count is 0, the fill-request flag is 1, the done and underflow flags are 0, and no load is offered to the shifter.
- R2: A push while the count is below 4 stores the frame behind the queued frames. The count goes up by one at the next clock edge.
- R3: A push while the count is 4 is dropped. The count stays at 4, the stored frames stay as they were, and neither the done flag nor the underflow flag changes.
- R4: sh_load_o is high in the same cycle as sh_ready_i when the count is non-zero and no flush is requested. sh_data_o then carries the oldest queued frame, so frames leave in push order.
- R5: Each load lowers the count by exactly one at the next edge. A load and an accepted push in the same cycle leave the count unchanged.
- R6: sh_done_i sets the done flag at the next edge, and the flag stays set. done_clr_i clears it. If a set and a clear come in the same cycle, the set wins.
- R7: If slave_mode_i and ext_start_i are both high while the count is 0, the underflow flag is set at the next edge. The flag is not set in master mode or while frames are queued. underflow_clr_i clears it, and a set in the same cycle as a clear wins.
- R8: flush_i empties the buffer, so the count is 0 after the edge. No load is offered in a flush cycle. A push in the same cycle is discarded.
- R9: After each edge the fill-request flag is 1 exactly when the new count is below 4, except that fill_clr_i forces it to 0 for the edge it is applied at. It comes back one edge later if there is still room.
- R10: dma_req_o equals the fill-request flag when req_route_i is 1 and is 0 otherwise. irq_o equals the flag when req_route_i is 0 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push register write strobe |
| push_data_i | input | 32 | Frame written with the push |
| flush_i | input | 1 | Clear-TX strobe; empties the buffer |
| fill_clr_i | input | 1 | Write-one-to-clear for the fill-request flag |
| done_clr_i | input | 1 | Write-one-to-clear for the done flag |
| underflow_clr_i | input | 1 | Write-one-to-clear for the underflow flag |
| req_route_i | input | 1 | 1 routes fill request to DMA, 0 to interrupt |
| slave_mode_i | input | 1 | Block operates as SPI slave |
| ext_start_i | input | 1 | External master begins a transfer |
| sh_ready_i | input | 1 | Shift register can take a frame |
| sh_done_i | input | 1 | Shift register finished a frame |
| sh_load_o | output | 1 | Frame handed to shift register this cycle |
| sh_data_o | output | 32 | Oldest queued frame |
| count_o | output | 3 | Number of queued frames, 0 to 4 |
| fill_flag_o | output | 1 | Fill-request flag |
| done_flag_o | output | 1 | Transfer-complete flag |
| underflow_flag_o | output | 1 | Underflow flag |
| dma_req_o | output | 1 | Fill request routed to DMA |
| irq_o | output | 1 | Fill request routed to interrupt |

## Verification
sh_load_o and sh_data_o respond in the same cycle as their inputs. The bench checks them one time step after driving, which is still before the next rising edge. The count and all three flags are registered, so they are due one edge after the stimulus that changes them. The bench checks them one time step after that edge and before it drives the next stimulus. The route outputs follow the fill-request flag with no extra delay and are checked at the same point as the flag.

// File: rtl/spi_tx_fifo_pkg.sv
package spi_tx_fifo_pkg;
  localparam int unsigned TXF_DATA_W = 32;
  localparam int unsigned TXF_DEPTH  = 4;

  typedef enum logic {
    ROUTE_IRQ = 1'b0,
    ROUTE_DMA = 1'b1
  } req_route_e;
endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  count_next_o,
  output logic              empty_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  // full is judged on the current count: a same-cycle pop does not make room
  assign wr_ok   = wr_i && !full && !flush_i;
  assign rd_ok   = rd_i && !empty_o && !flush_i;

  always_comb begin
    if (flush_i)             count_next_o = '0;
    else if (wr_ok && !rd_ok) count_next_o = cnt_q + CNT_W'(1);
    else if (rd_ok && !wr_ok) count_next_o = cnt_q - CNT_W'(1);
    else                      count_next_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= count_next_o;
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (wr_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
        if (rd_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (wr_ok && wr_ptr_q == PTR_W'(g)) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_ptr_q];
  assign count_o   = cnt_q;
endmodule

// File: rtl/w1c_flag.sv
module w1c_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tx_fill_req.sv
module tx_fill_req
  import spi_tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_next_i,
  input  logic             clr_i,
  input  req_route_e       route_i,
  output logic             fill_o,
  output logic             dma_req_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic fill_q;

  // re-arms one edge after a clear while room remains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fill_q <= 1'b1;
    else if (clr_i) fill_q <= 1'b0;
    else            fill_q <= (count_next_i != FULL_CNT);
  end

  assign fill_o    = fill_q;
  assign dma_req_o = fill_q && (route_i == ROUTE_DMA);
  assign irq_o     = fill_q && (route_i == ROUTE_IRQ);
endmodule

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo
  import spi_tx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = TXF_DATA_W,
  parameter int unsigned DEPTH  = TXF_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              flush_i,
  input  logic              fill_clr_i,
  input  logic              done_clr_i,
  input  logic              underflow_clr_i,
  input  logic              req_route_i,
  input  logic              slave_mode_i,
  input  logic              ext_start_i,
  input  logic              sh_ready_i,
  input  logic              sh_done_i,
  output logic              sh_load_o,
  output logic [DATA_W-1:0] sh_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              fill_flag_o,
  output logic              done_flag_o,
  output logic              underflow_flag_o,
  output logic              dma_req_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] count_next;
  logic             empty;
  logic             unf_set;
  req_route_e       route;

  assign route     = req_route_e'(req_route_i);
  assign sh_load_o = sh_ready_i && !empty && !flush_i;
  assign unf_set   = slave_mode_i && ext_start_i && empty;

  tx_fifo_store #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (push_i),
    .wr_data_i   (push_data_i),
    .rd_i        (sh_load_o),
    .flush_i     (flush_i),
    .rd_data_o   (sh_data_o),
    .count_o     (count_o),
    .count_next_o(count_next),
    .empty_o     (empty)
  );

  tx_fill_req #(
    .DEPTH(DEPTH)
  ) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_next_i(count_next),
    .clr_i       (fill_clr_i),
    .route_i     (route),
    .fill_o      (fill_flag_o),
    .dma_req_o   (dma_req_o),
    .irq_o       (irq_o)
  );

  w1c_flag u_done (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sh_done_i),
    .clr_i (done_clr_i),
    .flag_o(done_flag_o)
  );

  w1c_flag u_unf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (unf_set),
    .clr_i (underflow_clr_i),
    .flag_o(underflow_flag_o)
  );
endmodule

// File: rtl/spi_tx_fifo_chk.sv
module spi_tx_fifo_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             flush_i,
  input logic             slave_mode_i,
  input logic             ext_start_i,
  input logic             sh_done_i,
  input logic             sh_load_o,
  input logic [CNT_W-1:0] count_o,
  input logic             fill_flag_o,
  input logic             done_flag_o,
  input logic             underflow_flag_o,
  input logic             dma_req_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // R3
  full_push_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == FULL_CNT && push_i && !sh_load_o && !flush_i) |=> count_o == FULL_CNT);

  // R4
  load_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_load_o |-> (count_o != '0 && !flush_i));

  // R5
  load_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_load_o && !push_i) |=> count_o == $past(count_o) - CNT_W'(1));

  // R6
  done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_done_i |=> done_flag_o);

  // R7
  unf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_mode_i && ext_start_i && count_o == '0) |=> underflow_flag_o);

  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_o == '0);

  // R9
  full_no_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == FULL_CNT |-> !fill_flag_o);

  // R10
  route_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dma_req_o && irq_o) && ((dma_req_o || irq_o) == fill_flag_o));
endmodule

bind spi_tx_fifo spi_tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/spi_tx_fifo_tb_top.sv
module spi_tx_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 0, flush_i = 0, fill_clr_i = 0, done_clr_i = 0;
  logic        underflow_clr_i = 0, req_route_i = 0, slave_mode_i = 0;
  logic        ext_start_i = 0, sh_ready_i = 0, sh_done_i = 0;
  logic [31:0] push_data_i = '0;
  logic        sh_load_o, fill_flag_o, done_flag_o, underflow_flag_o, dma_req_o, irq_o;
  logic [31:0] sh_data_o;
  logic [2:0]  count_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_tx_fifo dut_i (.*);

  // {push, data, ready, exp_load, exp_data, exp_count, exp_fill}
  localparam logic [70:0] VEC [NV] = '{
    {1'b1, 32'h0000_00A1, 1'b0, 1'b0, 32'h0, 3'd1, 1'b1},
    {1'b1, 32'h0000_00A2, 1'b0, 1'b0, 32'h0, 3'd2, 1'b1},
    {1'b1, 32'h0000_00A3, 1'b0, 1'b0, 32'h0, 3'd3, 1'b1},
    {1'b1, 32'h0000_00A4, 1'b0, 1'b0, 32'h0, 3'd4, 1'b0},
    {1'b1, 32'h0000_00A5, 1'b0, 1'b0, 32'h0, 3'd4, 1'b0},
    {1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_00A1, 3'd3, 1'b1},
    {1'b1, 32'h0000_00B1, 1'b1, 1'b1, 32'h0000_00A2, 3'd3, 1'b1},
    {1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_00A3, 3'd2, 1'b1},
    {1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_00A4, 3'd1, 1'b1},
    {1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_00B1, 3'd0, 1'b1},
    {1'b0, 32'h0,         1'b1, 1'b0, 32'h0,         3'd0, 1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    push_i = 0; flush_i = 0; fill_clr_i = 0; done_clr_i = 0;
    underflow_clr_i = 0; ext_start_i = 0; sh_ready_i = 0; sh_done_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    // R1 during reset
    check("R1", "count in reset", count_o, 0);
    check("R1", "fill in reset", fill_flag_o, 1);
    rst_ni = 1'b1;
    #1;
    check("R1", "done", done_flag_o, 0);
    check("R1", "underflow", underflow_flag_o, 0);
    check("R1", "load", sh_load_o, 0);
    tick();
    check("R1", "fill after first edge", fill_flag_o, 1);

    // R2 R3 R4 R5 R9 table walk
    for (int i = 0; i < NV; i++) begin
      logic [70:0] v;
      v = VEC[i];
      idle();
      push_i = v[70]; push_data_i = v[69:38]; sh_ready_i = v[37];
      #1;
      check("R4", "load", sh_load_o, v[36]);
      if (v[36]) check("R4", "frame order", sh_data_o, v[35:4]);
      tick();
      check("R2/R5", "count", count_o, v[3:1]);
      check("R9", "fill", fill_flag_o, v[0]);
      check("R3", "done untouched", done_flag_o, 0);
      check("R3", "underflow untouched", underflow_flag_o, 0);
    end
    idle();

    // R10 routing
    req_route_i = 1; #1;
    check("R10", "dma", dma_req_o, 1);
    check("R10", "irq", irq_o, 0);
    req_route_i = 0; #1;
    check("R10", "dma", dma_req_o, 0);
    check("R10", "irq", irq_o, 1);

    // R9 clear then re-arm
    fill_clr_i = 1; tick();
    check("R9", "fill cleared", fill_flag_o, 0);
    check("R10", "irq follows", irq_o, 0);
    fill_clr_i = 0; tick();
    check("R9", "fill rearmed", fill_flag_o, 1);

    // R6 done flag
    sh_done_i = 1; tick();
    check("R6", "done set", done_flag_o, 1);
    sh_done_i = 0; tick();
    check("R6", "done sticky", done_flag_o, 1);
    done_clr_i = 1; tick();
    check("R6", "done cleared", done_flag_o, 0);
    sh_done_i = 1; tick();
    check("R6", "set beats clear", done_flag_o, 1);
    sh_done_i = 0; tick();
    check("R6", "clear alone", done_flag_o, 0);
    done_clr_i = 0;

    // R7 underflow
    ext_start_i = 1; slave_mode_i = 0; tick();
    check("R7", "master mode no flag", underflow_flag_o, 0);
    ext_start_i = 0; push_i = 1; push_data_i = 32'hC0; tick();
    push_i = 0; slave_mode_i = 1; ext_start_i = 1; tick();
    check("R7", "non-empty no flag", underflow_flag_o, 0);
    ext_start_i = 0; flush_i = 1; tick();
    check("R8", "flush empties", count_o, 0);
    flush_i = 0; ext_start_i = 1; tick();
    check("R7", "empty slave sets", underflow_flag_o, 1);
    underflow_clr_i = 1; tick();
    check("R7", "set beats clear", underflow_flag_o, 1);
    ext_start_i = 0; tick();
    check("R7", "clear alone", underflow_flag_o, 0);
    underflow_clr_i = 0; slave_mode_i = 0;

    // R8 flush beats push, no load
    push_i = 1; push_data_i = 32'hD1; tick();
    push_data_i = 32'hD2; tick();
    check("R2", "two queued", count_o, 2);
    push_data_i = 32'hD3; flush_i = 1; sh_ready_i = 1; #1;
    check("R8", "no load in flush", sh_load_o, 0);
    tick();
    check("R8", "flush wins over push", count_o, 0);
    flush_i = 0; sh_ready_i = 0; push_data_i = 32'hE1; tick();
    push_i = 0; sh_ready_i = 1; #1;
    check("R8", "only new frame left", sh_data_o, 32'hE1);
    tick();
    check("R5", "drained", count_o, 0);
    idle();

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule